// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general-purpose registers of a processor whose register view depends on its operating mode. Software addresses sixteen logical registers through a 4-bit index. The 5-bit mode input chooses which physical copy each index refers to. The low eight indices always reach one shared copy. Indices 8 to 12 have a second copy that only the fast-interrupt mode uses. Indices 13 and 14 have one copy for each exception mode and one that user and system modes share. Thirty storage registers exist. Index 15 is the program counter, which the block does not store: a read of it returns a value derived from the external instruction address.

The block has two combinational read ports and one write port. The write takes effect on the rising clock edge. A separate override input points every port at the user/system copies, whatever the current mode. An exception handler uses this to save or restore the interrupted task's registers in bulk.

Top module: `mode_bank_regfile`

## Requirements
- R1: While reset (active low) is asserted, every stored register clears to zero, so after reset every index 0 to 14 reads zero in every mode.
- R2: Indices 0 to 7 reach the same physical register in every mode. A value written in one mode reads back unchanged in all other modes.
- R3: Indices 8 to 12 have two copies. Mode 5'b10001 (fast interrupt) uses one copy and every other mode code uses the other.
- R4: Indices 13 and 14 have six copies each. User 5'b10000 and system 5'b11111 share one copy. Supervisor 5'b10011, abort 5'b10111, undefined 5'b11011, interrupt 5'b10010 and fast interrupt 5'b10001 each have their own copy.
- R5: A mode code outside the seven listed in R4 selects the user/system copies for every index.
- R6: While userBank is 1, both reads and the write use the user/system copies, whatever the mode code.
- R7: A read of index 15 on either port returns pcIn + 8 with bits [1:0] forced to zero, with wrap-around at 32 bits.
- R8: A write to index 15 is ignored: no stored register changes.
- R9: A write updates storage at the rising clock edge. A read of the same register in the write cycle returns the old value, and the new value is readable from the next cycle.
- R10: The two read ports are independent. Given the same index, they return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| mode | input | 5 | Current processor mode code |
| userBank | input | 1 | Forces the user/system copies on all ports |
| rdIdxA | input | 4 | Logical index, read port A |
| rdDataA | output | 32 | Read data, port A |
| rdIdxB | input | 4 | Logical index, read port B |
| rdDataB | output | 32 | Read data, port B |
| wrEn | input | 1 | Write enable |
| wrIdx | input | 4 | Logical index for the write |
| wrData | input | 32 | Write data |
| pcIn | input | 32 | Address of the current instruction |

## Verification
The bench writes a distinct value to every index in every mode, including one unlisted mode code, and then reads everything back in every mode. A decoder that shares too much makes one mode's value show up in another mode. One that shares too little loses the values of shared indices, or gives system mode a copy separate from user mode. Writes under the override in interrupt mode must land only in the user copies. A wrong override would corrupt the interrupt copy or miss the user copy. Index 15 is checked twice: program counter values with low bits set and near wrap-around must come back aligned, and a write to index 15 must leave all thirty stored registers as they were. Reads of the written register in the write cycle show whether the write leaks through combinationally.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

  localparam int IDX_W      = 4;
  localparam int MODE_W     = 5;
  localparam int SHARED_CNT = 8;
  localparam int MID_CNT    = 5;
  localparam int MID_COPIES = 2;
  localparam int TOP_CNT    = 2;
  localparam int TOP_COPIES = 6;
  localparam int MID_BASE   = SHARED_CNT;
  localparam int TOP_BASE   = MID_BASE + MID_CNT * MID_COPIES;
  localparam int PHYS_CNT   = TOP_BASE + TOP_CNT * TOP_COPIES;
  localparam int PHYS_W     = $clog2(PHYS_CNT);
  localparam int PC_IDX     = SHARED_CNT + MID_CNT + TOP_CNT;

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } cpuMode_e;

  typedef struct packed {
    logic              wrStrobe;
    logic [PHYS_W-1:0] wrSel;
    logic [PHYS_W-1:0] rdSelA;
    logic [PHYS_W-1:0] rdSelB;
    logic              pcSelA;
    logic              pcSelB;
  } bankCtl_t;

  // Maps a logical index onto storage, given the fast copy choice and top copy number
  function automatic logic [PHYS_W-1:0] physOf(input logic [IDX_W-1:0] idx,
                                               input logic midAlt,
                                               input int   topCopy);
    int r;
    int i;
    i = int'(idx);
    if (i < SHARED_CNT)
      r = i;
    else if (i < SHARED_CNT + MID_CNT)
      r = MID_BASE + (midAlt ? MID_CNT : 0) + (i - SHARED_CNT);
    else if (i < PC_IDX)
      r = TOP_BASE + topCopy * TOP_CNT + (i - SHARED_CNT - MID_CNT);
    else
      r = 0;
    return PHYS_W'(r);
  endfunction

endpackage

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import bankreg_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              userBank,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic [IDX_W-1:0]  rdIdxB,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  output bankCtl_t          ctl
);

  logic midAlt;
  int   topCopy;

  // Copy selection: the override and unknown codes fall back to copy zero
  always_comb begin
    midAlt  = 1'b0;
    topCopy = 0;
    if (!userBank) begin
      case (mode)
        MODE_SVC: topCopy = 1;
        MODE_ABT: topCopy = 2;
        MODE_UND: topCopy = 3;
        MODE_IRQ: topCopy = 4;
        MODE_FIQ: begin
          topCopy = 5;
          midAlt  = 1'b1;
        end
        default:  topCopy = 0;
      endcase
    end
  end

  always_comb begin
    ctl.wrStrobe = wrEn && (wrIdx != IDX_W'(PC_IDX));
    ctl.wrSel    = physOf(wrIdx, midAlt, topCopy);
    ctl.rdSelA   = physOf(rdIdxA, midAlt, topCopy);
    ctl.rdSelB   = physOf(rdIdxB, midAlt, topCopy);
    ctl.pcSelA   = (rdIdxA == IDX_W'(PC_IDX));
    ctl.pcSelB   = (rdIdxB == IDX_W'(PC_IDX));
  end

endmodule

// File: rtl/bank_store.sv
module bank_store
  import bankreg_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PC_OFFSET = 8,
  parameter int ALIGN_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankCtl_t          ctl,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] pcIn,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);

  localparam logic [DATA_W-1:0] ALIGN_MASK = ~DATA_W'((1 << ALIGN_W) - 1);

  logic [DATA_W-1:0] regs [PHYS_CNT];
  logic [DATA_W-1:0] pcView;

  for (genvar g = 0; g < PHYS_CNT; g++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regs[g] <= '0;
      else if (ctl.wrStrobe && (ctl.wrSel == PHYS_W'(g)))
        regs[g] <= wrData;
    end
  end

  assign pcView  = (pcIn + DATA_W'(PC_OFFSET)) & ALIGN_MASK;
  assign rdDataA = ctl.pcSelA ? pcView : regs[ctl.rdSelA];
  assign rdDataB = ctl.pcSelB ? pcView : regs[ctl.rdSelB];

endmodule

// File: rtl/mode_bank_regfile.sv
module mode_bank_regfile
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        mode,
  input  logic              userBank,
  input  logic [3:0]        rdIdxA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [3:0]        rdIdxB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [3:0]        wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] pcIn
);

  bankCtl_t ctl;

  bank_ctrl u_ctrl (
    .mode     (mode),
    .userBank (userBank),
    .rdIdxA   (rdIdxA),
    .rdIdxB   (rdIdxB),
    .wrEn     (wrEn),
    .wrIdx    (wrIdx),
    .ctl      (ctl)
  );

  bank_store #(.DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .wrData  (wrData),
    .pcIn    (pcIn),
    .rdDataA (rdDataA),
    .rdDataB (rdDataB)
  );

endmodule

// File: rtl/bank_checker.sv
module bank_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [4:0]        mode,
  input logic              userBank,
  input logic [3:0]        rdIdxA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [3:0]        rdIdxB,
  input logic [DATA_W-1:0] rdDataB,
  input logic              wrEn,
  input logic [3:0]        wrIdx,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] pcIn
);

  AST_WRITE_VISIBLE_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx != 4'hF) |=>
      (!(rdIdxA == $past(wrIdx) && mode == $past(mode) && userBank == $past(userBank))
       || rdDataA == $past(wrData))); // R9

  AST_SHARED_MODE_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(wrEn) && rdIdxA < 4'd8 && rdIdxA == $past(rdIdxA)) |->
      rdDataA == $past(rdDataA)); // R2

  AST_PC_VIEW: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdxB == 4'hF) |->
      (rdDataB[1:0] == 2'b00 && rdDataB[DATA_W-1:2] == (pcIn + DATA_W'(8)) >> 2)); // R7

  AST_PC_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx == 4'hF) |=>
      (!(rdIdxA == $past(rdIdxA) && mode == $past(mode) && userBank == $past(userBank)
         && rdIdxA != 4'hF) || rdDataA == $past(rdDataA))); // R8

  AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdxA == rdIdxB) |-> rdDataA == rdDataB); // R10

endmodule

bind mode_bank_regfile bank_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .mode     (mode),
  .userBank (userBank),
  .rdIdxA   (rdIdxA),
  .rdDataA  (rdDataA),
  .rdIdxB   (rdIdxB),
  .rdDataB  (rdDataB),
  .wrEn     (wrEn),
  .wrIdx    (wrIdx),
  .wrData   (wrData),
  .pcIn     (pcIn)
);

// File: tb/sim_mode_bank_regfile.sv
`timescale 1ns/1ps
module sim_mode_bank_regfile;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  mode = 5'b10000;
  logic        userBank = 1'b0;
  logic [3:0]  rdIdxA = '0;
  logic [3:0]  rdIdxB = '0;
  logic [31:0] rdDataA;
  logic [31:0] rdDataB;
  logic        wrEn = 1'b0;
  logic [3:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic [31:0] pcIn = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] model [int];
  logic [4:0] modes [8] = '{5'b10000, 5'b11111, 5'b10011, 5'b10111,
                            5'b11011, 5'b10010, 5'b10001, 5'b00101};

  always #2.5 clk = ~clk;

  mode_bank_regfile u0 (
    .clk(clk), .rstN(rstN), .mode(mode), .userBank(userBank),
    .rdIdxA(rdIdxA), .rdDataA(rdDataA), .rdIdxB(rdIdxB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData), .pcIn(pcIn)
  );

  // Which copy a (mode, override, index) triple reaches, as a flat key
  function automatic int keyOf(logic [4:0] m, logic ub, logic [3:0] idx);
    int copy;
    copy = 0;
    if (idx >= 4'd8 && !ub) begin
      if (idx <= 4'd12) copy = (m == 5'b10001) ? 5 : 0;
      else case (m)
        5'b10011: copy = 1;
        5'b10111: copy = 2;
        5'b11011: copy = 3;
        5'b10010: copy = 4;
        5'b10001: copy = 5;
        default:  copy = 0;
      endcase
    end
    return copy * 16 + int'(idx);
  endfunction

  function automatic logic [31:0] expect_(logic [3:0] idx);
    int k;
    if (idx == 4'hF) return (pcIn + 32'd8) & 32'hFFFF_FFFC;
    k = keyOf(mode, userBank, idx);
    return model.exists(k) ? model[k] : 32'h0;
  endfunction

  function automatic string regionTag(logic [3:0] idx);
    bit known;
    known = (mode == 5'b10000 || mode == 5'b11111 || mode == 5'b10011 || mode == 5'b10111 ||
             mode == 5'b11011 || mode == 5'b10010 || mode == 5'b10001);
    if (idx == 4'hF) return "R7";
    if (userBank) return "R6";
    if (!known) return "R5";
    if (idx < 4'd8) return "R2";
    if (idx < 4'd13) return "R3";
    return "R4";
  endfunction

  task automatic checkPort(string port, logic [3:0] idx, logic [31:0] act, string tag);
    logic [31:0] exp;
    string t;
    exp = expect_(idx);
    t = (tag == "") ? regionTag(idx) : tag;
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s port %s idx %0d mode %b ub %0d: actual %h expected %h",
               t, port, idx, mode, userBank, act, exp);
    end
  endtask

  task automatic step(logic [4:0] m, logic ub, logic [3:0] ra, logic [3:0] rb,
                      logic we, logic [3:0] wi, logic [31:0] wd, logic [31:0] pc, string tag);
    @(negedge clk);
    mode = m; userBank = ub; rdIdxA = ra; rdIdxB = rb;
    wrEn = we; wrIdx = wi; wrData = wd; pcIn = pc;
    #1;
    checkPort("A", ra, rdDataA, tag);
    checkPort("B", rb, rdDataB, tag);
    @(posedge clk);
    if (we && wi != 4'hF) model[keyOf(m, ub, wi)] = wd;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    model.delete();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: everything reads zero after reset
    for (int mi = 0; mi < 8; mi++)
      for (int i = 0; i < 15; i++)
        step(modes[mi], 1'b0, 4'(i), 4'(14 - i), 1'b0, 4'd0, 32'd0, 32'h100, "R1");

    // R9: write every index in every mode; same-cycle read shows the old value
    for (int mi = 0; mi < 8; mi++)
      for (int i = 0; i < 15; i++)
        step(modes[mi], 1'b0, 4'(i), 4'(i), 1'b1, 4'(i),
             {8'(mi), 8'hC3, 8'(i), 8'h5A}, 32'h200, "R9");

    // R2..R5: read back every index in every mode
    for (int mi = 0; mi < 8; mi++)
      for (int i = 0; i < 15; i++)
        step(modes[mi], 1'b0, 4'(i), 4'((i + 5) % 15), 1'b0, 4'd0, 32'd0, 32'h300, "");

    // R6: override writes in interrupt mode land in user copies only
    for (int i = 8; i < 15; i++)
      step(5'b10010, 1'b1, 4'(i), 4'(i), 1'b1, 4'(i), 32'hB000_0000 + 32'(i), 32'h0, "R6");
    for (int i = 8; i < 15; i++) begin
      step(5'b10000, 1'b0, 4'(i), 4'(i), 1'b0, 4'd0, 32'd0, 32'h0, "R6");
      step(5'b10010, 1'b0, 4'(i), 4'(i), 1'b0, 4'd0, 32'd0, 32'h0, "R6");
      step(5'b10001, 1'b1, 4'(i), 4'(i), 1'b0, 4'd0, 32'd0, 32'h0, "R6");
    end

    // R8: writes to index 15 change nothing
    step(5'b10011, 1'b0, 4'd13, 4'd0, 1'b1, 4'hF, 32'hDEAD_BEEF, 32'h0, "R8");
    step(5'b10000, 1'b0, 4'd15, 4'd8, 1'b1, 4'hF, 32'h1234_5678, 32'h0, "R8");
    for (int mi = 0; mi < 8; mi++)
      for (int i = 0; i < 15; i++)
        step(modes[mi], 1'b0, 4'(i), 4'(14 - i), 1'b0, 4'd0, 32'd0, 32'h0, "R8");

    // R7: program counter view with unaligned and wrapping inputs
    step(5'b10000, 1'b0, 4'hF, 4'hF, 1'b0, 4'd0, 32'd0, 32'h0000_1000, "R7");
    step(5'b10011, 1'b0, 4'hF, 4'd2, 1'b0, 4'd0, 32'd0, 32'h0000_1003, "R7");
    step(5'b10001, 1'b0, 4'd9, 4'hF, 1'b0, 4'd0, 32'd0, 32'hFFFF_FFFE, "R7");
    step(5'b10010, 1'b1, 4'hF, 4'hF, 1'b0, 4'd0, 32'd0, 32'hFFFF_FFF9, "R7");

    // R9: new value visible on the following cycle
    step(5'b10111, 1'b0, 4'd14, 4'd3, 1'b1, 4'd14, 32'hA5A5_0001, 32'h0, "R9");
    step(5'b10111, 1'b0, 4'd14, 4'd14, 1'b0, 4'd0, 32'd0, 32'h0, "R9");
    step(5'b11011, 1'b0, 4'd14, 4'd14, 1'b0, 4'd0, 32'd0, 32'h0, "R9");

    // R10: both ports on the same index
    for (int i = 0; i < 16; i++)
      step(modes[i % 8], 1'b0, 4'(i), 4'(i), 1'b0, 4'd0, 32'd0, 32'h40, "R10");

    finished = 1;
    summary();
    $finish;
  end

endmodule